// File: doc/BRIEF.md
# Zero-Page Byte-Pair Divide Sequencer

This block carries out the divide operation of an 8-bit accumulator processor. A start strobe takes a snapshot of the zero-page base, the X index, the accumulator and the stack pointer. The block then reads a 16-bit dividend from two adjacent zero-page bytes that start at base plus X. It divides that dividend by the accumulator with a restoring shift-subtract datapath that produces one quotient bit per clock. On success it writes the 8-bit quotient back to the accumulator, pushes the bit-inverted remainder onto the stack and hands back the decremented stack pointer.

The processor core owns the accumulator and stack-pointer registers. It loads them from `acc_o` and `sp_o` in the cycle in which the matching write-enable is high. The memory port is byte-wide and synchronous, and read data arrives one cycle after the read strobe. The divisor can be zero, or the quotient can fail to fit in 8 bits. In either case the block finishes early with an error flag and leaves the accumulator, the stack and the stack pointer untouched.

Top module: `zp_div_seq`

## Requirements
- R1: After a start the block issues exactly two reads, on consecutive cycles. The first goes to address {8'h00, (zz+X) mod 256} and the second to {8'h00, (zz+X+1) mod 256}, so both bytes stay in page zero.
- R2: The dividend is {second byte, first byte}. The divisor is the value of `acc_i` sampled in the start cycle.
- R3: When the divide succeeds, `acc_o` carries the quotient in the done cycle, with `acc_we_o` high in that cycle only.
- R4: When the divide succeeds, exactly one memory write takes place. It goes to address {STACK_PAGE (default 8'h01), sp}, where sp is the sampled stack pointer, and its data is the bitwise inverse of the remainder. It never overlaps a read.
- R5: When the divide succeeds, `sp_o` equals the sampled stack pointer minus one, modulo 256, and `sp_we_o` is high in the done cycle only.
- R6: `done_o` is a single-cycle pulse. On success it is high in the cycle that follows the 12th rising edge after the start edge, which is W+4 edges for W=8.
- R7: If the divisor is zero, or the high dividend byte is greater than or equal to the divisor, `done_o` and `err_o` rise together 3 edges after the start edge. In that case there is no memory write, and `acc_we_o` and `sp_we_o` stay low.
- R8: `busy_o` is high from the cycle after the start edge up to and including the done cycle. A start pulse during that window, together with any change on the operand inputs, has no effect on the operation in progress or on its results.
- R9: After reset the block is idle, and `busy_o`, `done_o`, `err_o`, `mem_rd_o`, `mem_wr_o`, `acc_we_o` and `sp_we_o` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts an operation when the block is idle |
| zp_base_i | input | 8 | Zero-page base operand |
| idx_x_i | input | 8 | X index |
| acc_i | input | 8 | Accumulator value, used as the divisor |
| sp_i | input | 8 | Current stack pointer |
| mem_addr_o | output | 16 | Memory address |
| mem_rd_o | output | 1 | Read strobe; data is returned on the next cycle |
| mem_wr_o | output | 1 | Write strobe |
| mem_wdata_o | output | 8 | Write data |
| mem_rdata_i | input | 8 | Read data |
| acc_o | output | 8 | New accumulator value (the quotient) |
| acc_we_o | output | 1 | Accumulator write enable |
| sp_o | output | 8 | New stack pointer |
| sp_we_o | output | 1 | Stack pointer write enable |
| done_o | output | 1 | Single-cycle completion pulse |
| err_o | output | 1 | Divide error, valid together with done_o |
| busy_o | output | 1 | Operation in progress |

## Verification
The assertions check properties that must hold on every cycle:
- Reads and writes never overlap.
- The high-byte read always follows the low-byte read at the next zero-page address, with wrap.
- The push lands in the stack page at the address one above the returned stack pointer.
- A push is always followed by a successful completion.
- `done_o` lasts a single cycle.
- An error never comes with a register write.
- The partial remainder stays below the divisor.

The actual quotient and inverted remainder values, the exact latencies, the decision between error and success, and the fact that starts arriving mid-operation are ignored can only be shown by the bench. It does this with directed wrap and boundary cases and with random operands compared against a reference model.

// File: rtl/zpdiv_pkg.sv
package zpdiv_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_LO,
    ST_RD_HI,
    ST_CHK,
    ST_DIV,
    ST_PUSH,
    ST_FIN
  } st_e;
endpackage

// File: rtl/zpdiv_core.sv
module zpdiv_core #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         step_i,
  input  logic [W-1:0] hi_i,
  input  logic [W-1:0] lo_i,
  input  logic [W-1:0] div_i,
  output logic [W-1:0] quot_o,
  output logic [W-1:0] rem_o
);
  logic [W-1:0] rem_q, sh_q, div_q;
  logic [W:0]   trial, diff;
  logic         ge;

  // partial remainder shifted left with the next dividend bit appended
  assign trial = {rem_q, sh_q[W-1]};
  assign diff  = trial - {1'b0, div_q};
  assign ge    = trial >= {1'b0, div_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q <= '0;
      sh_q  <= '0;
      div_q <= '0;
    end else if (load_i) begin
      rem_q <= hi_i;
      sh_q  <= lo_i;
      div_q <= div_i;
    end else if (step_i) begin
      rem_q <= ge ? diff[W-1:0] : trial[W-1:0];
      sh_q  <= {sh_q[W-2:0], ge};
    end
  end

  assign quot_o = sh_q;
  assign rem_o  = rem_q;

  AST_REM_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i && div_q != '0 && rem_q < div_q) |=> rem_q < div_q); // R3
endmodule

// File: rtl/zpdiv_agen.sv
module zpdiv_agen #(
  parameter int              W          = 8,
  parameter int              AW         = 16,
  parameter logic [AW-W-1:0] STACK_PAGE = 1
) (
  input  zpdiv_pkg::st_e st_i,
  input  logic [W-1:0]   zz_i,
  input  logic [W-1:0]   x_i,
  input  logic [W-1:0]   sp_i,
  output logic [AW-1:0]  addr_o,
  output logic           rd_o,
  output logic           wr_o
);
  import zpdiv_pkg::*;
  localparam int PW = AW - W;

  logic [W-1:0] zp_lo, zp_hi;
  // W-bit sums wrap inside page zero
  assign zp_lo = zz_i + x_i;
  assign zp_hi = zp_lo + W'(1);

  always_comb begin
    addr_o = '0;
    rd_o   = 1'b0;
    wr_o   = 1'b0;
    unique case (st_i)
      ST_RD_LO: begin addr_o = {{PW{1'b0}}, zp_lo}; rd_o = 1'b1; end
      ST_RD_HI: begin addr_o = {{PW{1'b0}}, zp_hi}; rd_o = 1'b1; end
      ST_PUSH:  begin addr_o = {STACK_PAGE, sp_i};  wr_o = 1'b1; end
      default: ;
    endcase
  end
endmodule

// File: rtl/zpdiv_ctrl.sv
module zpdiv_ctrl #(
  parameter int W = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic [W-1:0]   zz_i,
  input  logic [W-1:0]   x_i,
  input  logic [W-1:0]   acc_i,
  input  logic [W-1:0]   sp_i,
  input  logic [W-1:0]   rdata_i,
  output zpdiv_pkg::st_e st_o,
  output logic [W-1:0]   zz_o,
  output logic [W-1:0]   x_o,
  output logic [W-1:0]   div_o,
  output logic [W-1:0]   sp_o,
  output logic [W-1:0]   lo_o,
  output logic           load_o,
  output logic           step_o,
  output logic           err_o
);
  import zpdiv_pkg::*;
  localparam int CW = $clog2(W + 1);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  st_e           st_q;
  logic [CW-1:0] cnt_q;
  logic [W-1:0]  zz_q, x_q, div_q, sp_q, lo_q;
  logic          err_q, bad;

  // zero divisor, or quotient would need more than W bits
  assign bad = (div_q == '0) || (rdata_i >= div_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      zz_q  <= '0;
      x_q   <= '0;
      div_q <= '0;
      sp_q  <= '0;
      lo_q  <= '0;
      err_q <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          zz_q  <= zz_i;
          x_q   <= x_i;
          div_q <= acc_i;
          sp_q  <= sp_i;
          st_q  <= ST_RD_LO;
        end
        ST_RD_LO: st_q <= ST_RD_HI;
        ST_RD_HI: begin
          lo_q <= rdata_i;
          st_q <= ST_CHK;
        end
        ST_CHK: begin
          err_q <= bad;
          cnt_q <= '0;
          st_q  <= bad ? ST_FIN : ST_DIV;
        end
        ST_DIV: begin
          cnt_q <= cnt_q + CW'(1);
          if (cnt_q == LAST) st_q <= ST_PUSH;
        end
        ST_PUSH: st_q <= ST_FIN;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign st_o   = st_q;
  assign zz_o   = zz_q;
  assign x_o    = x_q;
  assign div_o  = div_q;
  assign sp_o   = sp_q;
  assign lo_o   = lo_q;
  assign load_o = (st_q == ST_CHK) && !bad;
  assign step_o = (st_q == ST_DIV);
  assign err_o  = err_q;

  AST_DIV_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_PUSH) |-> $past(st_q) == ST_DIV); // R6
endmodule

// File: rtl/zp_div_seq.sv
module zp_div_seq #(
  parameter int              W          = 8,
  parameter int              AW         = 16,
  parameter logic [AW-W-1:0] STACK_PAGE = 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [W-1:0]  zp_base_i,
  input  logic [W-1:0]  idx_x_i,
  input  logic [W-1:0]  acc_i,
  input  logic [W-1:0]  sp_i,
  output logic [AW-1:0] mem_addr_o,
  output logic          mem_rd_o,
  output logic          mem_wr_o,
  output logic [W-1:0]  mem_wdata_o,
  input  logic [W-1:0]  mem_rdata_i,
  output logic [W-1:0]  acc_o,
  output logic          acc_we_o,
  output logic [W-1:0]  sp_o,
  output logic          sp_we_o,
  output logic          done_o,
  output logic          err_o,
  output logic          busy_o
);
  import zpdiv_pkg::*;

  st_e          st;
  logic [W-1:0] zz, xv, dv, spv, lo, quot, rem;
  logic         load, step, err_q;

  zpdiv_ctrl #(.W(W)) u_ctrl (
    .clk_i, .rst_ni, .start_i,
    .zz_i(zp_base_i), .x_i(idx_x_i), .acc_i, .sp_i,
    .rdata_i(mem_rdata_i),
    .st_o(st), .zz_o(zz), .x_o(xv), .div_o(dv), .sp_o(spv), .lo_o(lo),
    .load_o(load), .step_o(step), .err_o(err_q)
  );

  zpdiv_core #(.W(W)) u_core (
    .clk_i, .rst_ni,
    .load_i(load), .step_i(step),
    .hi_i(mem_rdata_i), .lo_i(lo), .div_i(dv),
    .quot_o(quot), .rem_o(rem)
  );

  zpdiv_agen #(.W(W), .AW(AW), .STACK_PAGE(STACK_PAGE)) u_agen (
    .st_i(st), .zz_i(zz), .x_i(xv), .sp_i(spv),
    .addr_o(mem_addr_o), .rd_o(mem_rd_o), .wr_o(mem_wr_o)
  );

  assign mem_wdata_o = ~rem;
  assign done_o      = (st == ST_FIN);
  assign err_o       = done_o && err_q;
  assign acc_we_o    = done_o && !err_q;
  assign sp_we_o     = done_o && !err_q;
  assign acc_o       = quot;
  assign sp_o        = spv - W'(1);
  assign busy_o      = (st != ST_IDLE);

  AST_RW_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_rd_o && mem_wr_o)); // R4
  AST_HI_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_rd_o && $past(mem_rd_o)) |->
      (mem_addr_o[W-1:0] == $past(mem_addr_o[W-1:0]) + W'(1)) &&
      (mem_addr_o[AW-1:W] == '0)); // R1
  AST_PUSH_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_o |-> (mem_addr_o[AW-1:W] == STACK_PAGE) &&
                 (mem_addr_o[W-1:0] == sp_o + W'(1))); // R4
  AST_PUSH_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_o |=> done_o && !err_o && sp_we_o && acc_we_o); // R5
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R6
  AST_ERR_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !acc_we_o && !sp_we_o && !mem_wr_o); // R7
  AST_BUSY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> busy_o); // R8
endmodule

// File: tb/tb_zp_div_seq.sv
module tb_zp_div_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  zz = '0, xi = '0, acc = '0, sp = '0;
  logic [15:0] addr;
  logic        rd, wr, acc_we, sp_we, done, err, busy;
  logic [7:0]  wdata, rdata, acc_n, sp_n;

  int checks = 0, fails = 0;
  logic [7:0]  zpm [256];
  int          rd_cnt, wr_cnt;
  logic [15:0] rd_log [2];
  logic [15:0] wr_addr;
  logic [7:0]  wr_dat;

  always #2 clk = ~clk;

  zp_div_seq dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .zp_base_i(zz), .idx_x_i(xi), .acc_i(acc), .sp_i(sp),
    .mem_addr_o(addr), .mem_rd_o(rd), .mem_wr_o(wr), .mem_wdata_o(wdata),
    .mem_rdata_i(rdata), .acc_o(acc_n), .acc_we_o(acc_we),
    .sp_o(sp_n), .sp_we_o(sp_we), .done_o(done), .err_o(err), .busy_o(busy)
  );

  // memory model, one-cycle read latency
  always @(posedge clk) begin
    if (rd) begin
      rdata <= (addr[15:8] == 8'h00) ? zpm[addr[7:0]] : 8'h5A;
      if (rd_cnt < 2) rd_log[rd_cnt] <= addr;
      rd_cnt <= rd_cnt + 1;
    end
    if (wr) begin
      wr_addr <= addr;
      wr_dat  <= wdata;
      wr_cnt  <= wr_cnt + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit exp_err(input logic [7:0] hi, input logic [7:0] d);
    return (d == 8'd0) || (hi >= d);
  endfunction

  task automatic run_op(input logic [7:0] z, input logic [7:0] x, input logic [7:0] a,
                        input logic [7:0] s, input logic [7:0] lo, input logic [7:0] hi,
                        input bit noisy);
    logic [7:0]  a_lo, a_hi, q, r;
    logic [15:0] dvd;
    bit          e;
    int          k;
    logic        got_err, got_awe, got_swe, b_ok;
    logic [7:0]  got_acc, got_sp;
    a_lo = z + x;
    a_hi = a_lo + 8'd1;
    zpm[a_lo] = lo;
    zpm[a_hi] = hi;
    dvd = {hi, lo};
    e = exp_err(hi, a);
    q = e ? 8'd0 : 8'(dvd / {8'd0, a});
    r = e ? 8'd0 : 8'(dvd % {8'd0, a});
    @(negedge clk);
    rd_cnt = 0; wr_cnt = 0;
    zz = z; xi = x; acc = a; sp = s; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    k = 0; b_ok = 1'b1;
    got_err = 0; got_awe = 0; got_swe = 0; got_acc = 0; got_sp = 0;
    while (k < 64) begin
      if (noisy && k < 6) begin
        start = 1'b1; zz = ~z; xi = x ^ 8'h33; acc = a + 8'd7; sp = s ^ 8'hF0;
      end else start = 1'b0;
      @(posedge clk);
      k++;
      @(negedge clk);
      if (!busy) b_ok = 1'b0;
      if (done) begin
        got_err = err; got_awe = acc_we; got_swe = sp_we;
        got_acc = acc_n; got_sp = sp_n;
        break;
      end
    end
    start = 1'b0;
    @(negedge clk);
    chk(b_ok, "R8 busy window", b_ok, 1);
    chk(!done, "R6 done single cycle", done, 0);
    chk(rd_cnt == 2, "R1 read count", rd_cnt, 2);
    chk(rd_log[0] == {8'h00, a_lo}, "R1 low address", rd_log[0], {8'h00, a_lo});
    chk(rd_log[1] == {8'h00, a_hi}, "R1 high address", rd_log[1], {8'h00, a_hi});
    chk(got_err == e, "R7 error flag", got_err, e);
    if (e) begin
      chk(k == 3, "R7 error latency", k, 3);
      chk(wr_cnt == 0, "R7 no push", wr_cnt, 0);
      chk(!got_awe && !got_swe, "R7 no reg write", {got_awe, got_swe}, 0);
    end else begin
      chk(k == 12, "R6 latency", k, 12);
      chk(got_awe, "R3 acc write enable", got_awe, 1);
      chk(got_acc == q, "R2 R3 quotient", got_acc, q);
      chk(wr_cnt == 1, "R4 single push", wr_cnt, 1);
      chk(wr_addr == {8'h01, s}, "R4 push address", wr_addr, {8'h01, s});
      chk(wr_dat == ~r, "R4 inverted remainder", wr_dat, ~r);
      chk(got_swe && got_sp == s - 8'd1, "R5 stack pointer", got_sp, s - 8'd1);
    end
    chk(!acc_we && !sp_we, "R3 R5 enables one cycle", {acc_we, sp_we}, 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) zpm[i] = 8'(i * 7);
    rd_cnt = 0; wr_cnt = 0; rdata = '0;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(!busy && !done && !err && !rd && !wr && !acc_we && !sp_we,
        "R9 reset idle", {busy, done, err, rd, wr, acc_we, sp_we}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !rd && !wr, "R9 after reset", {busy, done, rd, wr}, 0);
    // directed corners
    run_op(8'h10, 8'h05, 8'd7,   8'hFF, 8'd100, 8'd0, 1'b0);  // R2 small
    run_op(8'hFF, 8'h00, 8'hFF,  8'h80, 8'hFF, 8'hFE, 1'b0);  // R1 wrap, max quotient
    run_op(8'h80, 8'h7F, 8'd3,   8'h00, 8'h01, 8'h02, 1'b0);  // R1 wrap, R5 sp wrap
    run_op(8'h20, 8'h00, 8'd0,   8'h40, 8'h12, 8'h00, 1'b0);  // R7 zero divisor
    run_op(8'h30, 8'h01, 8'd9,   8'h40, 8'h00, 8'd9,  1'b0);  // R7 hi == divisor
    run_op(8'h30, 8'h01, 8'd9,   8'h40, 8'hFF, 8'd8,  1'b0);  // R3 boundary hi = d-1
    run_op(8'h44, 8'h11, 8'd13,  8'h70, 8'h99, 8'd5,  1'b1);  // R8 starts while busy
    run_op(8'h44, 8'h11, 8'd1,   8'h70, 8'h99, 8'd0,  1'b0);  // divide by one
    // random
    for (int n = 0; n < 60; n++) begin
      logic [7:0] a, h;
      a = 8'($urandom);
      h = (n % 5 == 0) ? 8'($urandom) : ((a == 0) ? 8'd0 : 8'($urandom % a));
      run_op(8'($urandom), 8'($urandom), a, 8'($urandom), 8'($urandom), h, n % 7 == 0);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule